// File: doc/BRIEF.md
# Managed-Flash Boot Sequencer

This block sits on the device side of a managed-flash card bus and decides, right after reset, whether the host is asking for a boot transfer. The host asks by holding the command line low without a break for a set number of clocks, before it sends any command. If the host releases the line too early, or a normal command is decoded first, the block goes quiet. It then refuses boot until the next hardware reset.

Once boot is recognised, the block waits a programmable number of cycles and, if configured to, drives a three-cycle acknowledge pattern on the data line. It waits again and then streams the boot partition, fetched byte by byte through a simple read port. The data goes out as framed blocks, each carrying its own CRC16. The stream ends by itself after the configured amount of data. It also stops within two cycles whenever the host raises the command line. When the block is neither streaming nor armed, it reports idle, so the normal initialisation command path can take over.

Top module: `boot_seq`

## Requirements
- R1: After a synchronous reset the block is armed: `dat_oe_o`, `idle_o` and `locked_o` are all 0.
- R2: While armed with boot enabled, `cmd_i` sampled low on `LOW_THRESH` consecutive clock edges starts a boot at that edge. Once that count is reached, raising `cmd_i` on the next edge yields no lockout; the block ends idle with `locked_o` 0.
- R3: While armed, either of two events locks the block out: `cmd_i` rising after 1 to `LOW_THRESH`-1 low samples, or a pulse on `cmd_strobe_i`. When locked, `locked_o` and `idle_o` are 1 and the data line is never driven. The lock persists until `rst_n` is asserted.
- R4: With `cfg_boot_en_i` at 0 the block goes to idle within two cycles of reset and never drives the data line; `locked_o` stays 0.
- R5: With `cfg_ack_en_i` at 1, the data line is released for `ACK_DELAY` cycles after boot recognition. It is then driven 0, 1, 0 on three consecutive cycles. With `cfg_ack_en_i` at 0, no pattern is sent.
- R6: After the acknowledge slot (or the first delay when acknowledge is off), the line stays released for `DATA_DELAY` cycles before the blocks begin. Each block is a start bit 0, then `BLK_BYTES` bytes MSB first at ascending read addresses starting at 0, then a 16-bit CRC, then an end bit 1. The CRC uses polynomial 0x1021 with zero initial value, runs over the block's data bits, and is sent MSB first. Between blocks the line is released for `BLK_GAP` cycles.
- R7: The stream holds `cfg_size_mult_i` × `BLKS_PER_UNIT` blocks; a multiplier of 0 sends no block. After the last end bit the line is released and `idle_o` rises.
- R8: If `cmd_i` is sampled high while a start, data or CRC bit is on the line, the next cycle drives an end bit 1 and the cycle after releases the line. The block then goes idle without lockout.
- R9: If `cmd_i` is sampled high during the acknowledge, a delay or an inter-block gap, the line is released from the next cycle and the block goes idle.
- R10: A `boot_rearm_i` pulse while idle with boot enabled re-arms detection, so a further low period starts a new boot. While locked the pulse has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| cmd_i | input | 1 | Sampled command line level |
| cmd_strobe_i | input | 1 | One-cycle pulse: a normal command was decoded |
| boot_rearm_i | input | 1 | One-cycle pulse: boot-arming reset command decoded |
| cfg_boot_en_i | input | 1 | Boot partition enabled |
| cfg_ack_en_i | input | 1 | Send acknowledge pattern |
| cfg_size_mult_i | input | 8 | Boot size multiplier |
| rd_addr_o | output | ADDR_W | Byte address into the boot partition |
| rd_data_i | input | 8 | Byte at `rd_addr_o`, valid in the same cycle |
| dat_o | output | 1 | Data line value (1 while released) |
| dat_oe_o | output | 1 | Data line drive enable |
| idle_o | output | 1 | Block idle (after boot, when disabled, or locked) |
| locked_o | output | 1 | Locked out of boot until reset |

## Verification
The hardest case to reach from the ports is an abort that lands on one particular bit of the frame. Examples are a bit deep inside a block's CRC, the middle acknowledge cycle, or the gap between two blocks. The bench first builds the entire expected line sequence for a configuration, cycle by cycle, from the delays, the block size and a software CRC. It then raises the command line right after checking a chosen index of that sequence, so each abort point is hit exactly. The threshold edges are approached the same way: lockout at one cycle short of the threshold, and clean recognition at exactly the threshold.

// File: rtl/boot_pkg.sv
// Shared state encodings for the boot sequencer.
// Assumes: used by boot_entry_detect and boot_seq only.
package boot_pkg;

    typedef enum logic [1:0] {
        DET_ARM,
        DET_BOOT,
        DET_IDLE,
        DET_LOCK
    } det_state_t;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_GAP1,
        ST_ACK,
        ST_GAP2,
        ST_START,
        ST_DATA,
        ST_CRC,
        ST_END,
        ST_BGAP,
        ST_TERM
    } strm_state_t;

endpackage

// File: rtl/boot_entry_detect.sv
// Boot entry detector: counts consecutive low samples of the command line
// after reset and decides between boot, idle and permanent lockout.
// Assumes: cmd_strobe_i / rearm_i are single-cycle pulses from the command
// decoder; stream_done_i pulses once when the data streamer has finished.
module boot_entry_detect
    import boot_pkg::*;
#(
    parameter int LOW_THRESH = 74
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_i,
    input  logic cmd_strobe_i,
    input  logic rearm_i,
    input  logic boot_en_i,
    input  logic stream_done_i,
    output logic boot_go_o,
    output logic idle_o,
    output logic locked_o
);

    localparam int CNT_W = $clog2(LOW_THRESH + 1);

    det_state_t       st;
    logic [CNT_W-1:0] low_cnt;

    // Boot starts on the edge that sees the threshold-th low sample.
    assign boot_go_o = (st == DET_ARM) && boot_en_i && !cmd_strobe_i && !cmd_i
                       && (low_cnt == CNT_W'(LOW_THRESH - 1));

    // Detection state machine and low-cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= DET_ARM;
            low_cnt <= '0;
        end else begin
            case (st)
                DET_ARM: begin
                    if (!boot_en_i) begin
                        st <= DET_IDLE;
                    end else if (cmd_strobe_i) begin
                        st <= DET_LOCK;
                    end else if (!cmd_i) begin
                        if (low_cnt == CNT_W'(LOW_THRESH - 1)) begin
                            st <= DET_BOOT;
                        end else begin
                            low_cnt <= low_cnt + 1'b1;
                        end
                    end else if (low_cnt != '0) begin
                        st <= DET_LOCK;
                    end
                end
                DET_BOOT: begin
                    if (stream_done_i) begin
                        st <= DET_IDLE;
                    end
                end
                DET_IDLE: begin
                    if (rearm_i && boot_en_i) begin
                        st      <= DET_ARM;
                        low_cnt <= '0;
                    end
                end
                default: st <= DET_LOCK;
            endcase
        end
    end

    // Status decode.
    assign idle_o   = (st == DET_IDLE) || (st == DET_LOCK);
    assign locked_o = (st == DET_LOCK);

endmodule

// File: rtl/boot_crc16.sv
// Serial CRC16 (poly 0x1021, zero init) with a shift-out mode.
// Assumes: clr_i, calc_i and shift_i are mutually exclusive in use;
// clr_i wins if several are high.
module boot_crc16 (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic calc_i,
    input  logic bit_i,
    input  logic shift_i,
    output logic msb_o
);

    logic [15:0] crc_q;
    logic        fb;

    assign fb = crc_q[15] ^ bit_i;

    // Accumulate data bits, or shift the result out MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            crc_q <= '0;
        end else if (calc_i) begin
            crc_q <= {crc_q[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
        end else if (shift_i) begin
            crc_q <= {crc_q[14:0], 1'b0};
        end
    end

    assign msb_o = crc_q[15];

endmodule

// File: rtl/boot_seq.sv
// Boot sequencer top: entry detection, optional acknowledge, framed block
// streaming of the boot partition and abort on command-line release.
// Assumes: rd_data_i is a same-cycle combinational read of rd_addr_o;
// configuration inputs are stable from reset until boot ends;
// BLK_BYTES and BLKS_PER_UNIT are powers of two, BLK_BYTES >= 2, delays >= 1.
module boot_seq
    import boot_pkg::*;
#(
    parameter int LOW_THRESH    = 74,
    parameter int ACK_DELAY     = 64,
    parameter int DATA_DELAY    = 256,
    parameter int BLK_BYTES     = 512,
    parameter int BLKS_PER_UNIT = 256,
    parameter int BLK_GAP       = 4,
    localparam int BLK_SHIFT    = $clog2(BLK_BYTES),
    localparam int UNIT_SHIFT   = $clog2(BLKS_PER_UNIT * BLK_BYTES),
    localparam int ADDR_W       = 8 + UNIT_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_i,
    input  logic              cmd_strobe_i,
    input  logic              boot_rearm_i,
    input  logic              cfg_boot_en_i,
    input  logic              cfg_ack_en_i,
    input  logic [7:0]        cfg_size_mult_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [7:0]        rd_data_i,
    output logic              dat_o,
    output logic              dat_oe_o,
    output logic              idle_o,
    output logic              locked_o
);

    localparam int MAX_AD = (ACK_DELAY > DATA_DELAY) ? ACK_DELAY : DATA_DELAY;
    localparam int MAX_BG = (BLK_GAP > 16) ? BLK_GAP : 16;
    localparam int MAX_D  = (MAX_AD > MAX_BG) ? MAX_AD : MAX_BG;
    localparam int CNT_W  = $clog2(MAX_D + 1);

    strm_state_t       st;
    logic [CNT_W-1:0]  cnt;
    logic [2:0]        bit_q;
    logic [ADDR_W-1:0] addr_q;
    logic              last_blk_q;
    logic              done_q;

    logic              boot_go;
    logic              crc_msb;
    logic              data_bit;
    logic [ADDR_W-1:0] total_bytes;
    logic [ADDR_W-1:0] last_addr;
    logic              blk_last_byte;

    // Entry detection and lockout.
    boot_entry_detect #(
        .LOW_THRESH (LOW_THRESH)
    ) u_detect (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_i         (cmd_i),
        .cmd_strobe_i  (cmd_strobe_i),
        .rearm_i       (boot_rearm_i),
        .boot_en_i     (cfg_boot_en_i),
        .stream_done_i (done_q),
        .boot_go_o     (boot_go),
        .idle_o        (idle_o),
        .locked_o      (locked_o)
    );

    // Per-block CRC over the data bits.
    boot_crc16 u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (st == ST_START),
        .calc_i  (st == ST_DATA),
        .bit_i   (data_bit),
        .shift_i (st == ST_CRC),
        .msb_o   (crc_msb)
    );

    // Size and position decode.
    assign total_bytes   = {cfg_size_mult_i, {UNIT_SHIFT{1'b0}}};
    assign last_addr     = total_bytes - ADDR_W'(1);
    assign blk_last_byte = &addr_q[BLK_SHIFT-1:0];
    assign data_bit      = rd_data_i[3'd7 - bit_q];
    assign rd_addr_o     = addr_q;

    // Stream state machine: delays, acknowledge, framed blocks, abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_OFF;
            cnt        <= '0;
            bit_q      <= '0;
            addr_q     <= '0;
            last_blk_q <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                ST_OFF: begin
                    if (boot_go) begin
                        st     <= ST_GAP1;
                        cnt    <= '0;
                        addr_q <= '0;
                    end
                end
                ST_GAP1: begin
                    if (cmd_i) begin
                        st     <= ST_OFF;
                        done_q <= 1'b1;
                    end else if (cnt == CNT_W'(ACK_DELAY - 1)) begin
                        cnt <= '0;
                        st  <= cfg_ack_en_i ? ST_ACK : ST_GAP2;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_ACK: begin
                    if (cmd_i) begin
                        st     <= ST_OFF;
                        done_q <= 1'b1;
                    end else if (cnt == CNT_W'(2)) begin
                        cnt <= '0;
                        st  <= ST_GAP2;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_GAP2: begin
                    if (cmd_i) begin
                        st     <= ST_OFF;
                        done_q <= 1'b1;
                    end else if (cnt == CNT_W'(DATA_DELAY - 1)) begin
                        cnt <= '0;
                        if (total_bytes == '0) begin
                            st     <= ST_OFF;
                            done_q <= 1'b1;
                        end else begin
                            st <= ST_START;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_START: begin
                    if (cmd_i) begin
                        st <= ST_TERM;
                    end else begin
                        st    <= ST_DATA;
                        bit_q <= '0;
                    end
                end
                ST_DATA: begin
                    if (cmd_i) begin
                        st <= ST_TERM;
                    end else if (bit_q == 3'd7) begin
                        bit_q  <= '0;
                        addr_q <= addr_q + 1'b1;
                        if (blk_last_byte) begin
                            st         <= ST_CRC;
                            cnt        <= '0;
                            last_blk_q <= (addr_q == last_addr);
                        end
                    end else begin
                        bit_q <= bit_q + 1'b1;
                    end
                end
                ST_CRC: begin
                    if (cmd_i) begin
                        st <= ST_TERM;
                    end else if (cnt == CNT_W'(15)) begin
                        cnt <= '0;
                        st  <= ST_END;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_END: begin
                    if (cmd_i || last_blk_q) begin
                        st     <= ST_OFF;
                        done_q <= 1'b1;
                    end else begin
                        st  <= ST_BGAP;
                        cnt <= '0;
                    end
                end
                ST_BGAP: begin
                    if (cmd_i) begin
                        st     <= ST_OFF;
                        done_q <= 1'b1;
                    end else if (cnt == CNT_W'(BLK_GAP - 1)) begin
                        cnt <= '0;
                        st  <= ST_START;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    st     <= ST_OFF;
                    done_q <= 1'b1;
                end
            endcase
        end
    end

    // Data line drive decode from the stream state.
    always_comb begin
        dat_oe_o = 1'b1;
        dat_o    = 1'b1;
        case (st)
            ST_ACK:   dat_o = (cnt == CNT_W'(1));
            ST_START: dat_o = 1'b0;
            ST_DATA:  dat_o = data_bit;
            ST_CRC:   dat_o = crc_msb;
            ST_END:   dat_o = 1'b1;
            ST_TERM:  dat_o = 1'b1;
            default:  dat_oe_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/boot_seq_chk.sv
// Temporal checks on the boot sequencer's ports, bound to every instance.
// Assumes: reset is held for at least one clock edge at start-up.
module boot_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_i,
    input logic dat_o,
    input logic dat_oe_o,
    input logic idle_o,
    input logic locked_o
);

    // R3
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(locked_o) && $past(rst_n)) |-> locked_o);

    // R3
    lock_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |-> (!dat_oe_o && idle_o));

    // R8
    abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i && $past(cmd_i)) |=> !dat_oe_o);

    // R6
    first_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dat_oe_o) |-> !dat_o);

    // R7
    drive_not_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dat_oe_o |-> !idle_o);

endmodule

bind boot_seq boot_seq_chk u_boot_seq_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_i    (cmd_i),
    .dat_o    (dat_o),
    .dat_oe_o (dat_oe_o),
    .idle_o   (idle_o),
    .locked_o (locked_o)
);

// File: tb/tb_boot_seq.sv
module tb_boot_seq;

    localparam int T   = 10;
    localparam int AD  = 3;
    localparam int DD  = 4;
    localparam int BB  = 4;
    localparam int BPU = 2;
    localparam int BG  = 2;
    localparam int AW  = 8 + $clog2(BPU * BB);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd = 1'b1;
    logic          strobe = 1'b0;
    logic          rearm = 1'b0;
    logic          boot_en = 1'b1;
    logic          ack_en = 1'b0;
    logic [7:0]    mult = 8'd1;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data;
    logic          dat, oe, idle, locked;

    int total = 0;
    int bad = 0;

    bit exp_oe  [0:1023];
    bit exp_dat [0:1023];
    bit exp_frm [0:1023];
    int n_sym;

    always #4 clk = ~clk;

    function automatic logic [7:0] mem_byte(input int a);
        return 8'((a * 29 + 7) ^ (a >> 3));
    endfunction

    assign rd_data = mem_byte(int'(rd_addr));

    boot_seq #(
        .LOW_THRESH(T), .ACK_DELAY(AD), .DATA_DELAY(DD),
        .BLK_BYTES(BB), .BLKS_PER_UNIT(BPU), .BLK_GAP(BG)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .cmd_strobe_i(strobe),
        .boot_rearm_i(rearm), .cfg_boot_en_i(boot_en), .cfg_ack_en_i(ack_en),
        .cfg_size_mult_i(mult), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
        .dat_o(dat), .dat_oe_o(oe), .idle_o(idle), .locked_o(locked)
    );

    task automatic check(input string req, input bit ok, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cmd = 1'b1; strobe = 1'b0; rearm = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive CMD low now and advance to the negedge after the T-th low edge.
    task automatic go_low();
        cmd = 1'b0;
        repeat (T) @(negedge clk);
    endtask

    task automatic push(input bit o, input bit d, input bit f);
        exp_oe[n_sym] = o; exp_dat[n_sym] = d; exp_frm[n_sym] = f;
        n_sym++;
    endtask

    // Expected line sequence from boot recognition onward (R5, R6, R7).
    task automatic build(input bit a, input int m);
        logic [15:0] c;
        bit fb, d;
        n_sym = 0;
        for (int i = 0; i < AD; i++) push(0, 1, 0);
        if (a) begin
            push(1, 0, 0); push(1, 1, 0); push(1, 0, 0);
        end
        for (int i = 0; i < DD; i++) push(0, 1, 0);
        for (int b = 0; b < m * BPU; b++) begin
            push(1, 0, 1);
            c = 16'h0000;
            for (int y = 0; y < BB; y++) begin
                for (int k = 7; k >= 0; k--) begin
                    d  = mem_byte(b * BB + y)[k];
                    fb = c[15] ^ d;
                    c  = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
                    push(1, d, 1);
                end
            end
            for (int k = 15; k >= 0; k--) push(1, c[k], 1);
            push(1, 1, 0);
            if (b < m * BPU - 1) for (int g = 0; g < BG; g++) push(0, 1, 0);
        end
        push(0, 1, 0); push(0, 1, 0);
    endtask

    // Compare the line to the expected list; abort after index ab (-1 = none).
    task automatic run_stream(input string req, input int ab);
        for (int k = 0; k < n_sym; k++) begin
            check(req, oe == exp_oe[k], oe, exp_oe[k]);
            if (exp_oe[k]) check(req, dat == exp_dat[k], dat, exp_dat[k]);
            if (k == ab) begin
                cmd = 1'b1;
                @(negedge clk);
                if (exp_frm[k]) begin
                    check("R8 end bit", oe && dat, {oe, dat}, 3);
                    @(negedge clk);
                    check("R8 release", !oe, oe, 0);
                end else begin
                    check("R9 release", !oe, oe, 0);
                end
                repeat (3) @(negedge clk);
                check(exp_frm[k] ? "R8 idle" : "R9 idle", idle && !locked, {idle, locked}, 2);
                return;
            end
            @(negedge clk);
        end
        check("R7 idle after stream", idle && !locked, {idle, locked}, 2);
    endtask

    task automatic watch_silent(input string req, input int n);
        bit any = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (oe) any = 1;
        end
        check(req, !any, any, 0);
    endtask

    initial begin
        #(8 * 150000);
        bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();
        @(negedge clk);
        check("R1 reset oe", !oe, oe, 0);
        check("R1 reset idle", !idle, idle, 0);
        check("R1 reset locked", !locked, locked, 0);

        // R5 R6 R7 sweep over acknowledge and size multiplier
        for (int a = 0; a < 2; a++) begin
            for (int m = 0; m < 4; m++) begin
                ack_en = a[0]; mult = 8'(m);
                do_reset();
                go_low();
                build(a[0], m);
                run_stream(a[0] ? "R5/R6/R7 ack" : "R6/R7 noack", -1);
            end
        end

        // R10 rearm after a completed boot
        cmd = 1'b1; rearm = 1'b1;
        @(negedge clk);
        rearm = 1'b0;
        go_low();
        run_stream("R10 rearm boot", -1);

        // R8 abort mid data and mid CRC
        ack_en = 1'b0; mult = 8'd1;
        do_reset(); go_low(); build(0, 1);
        run_stream("R8 data abort", AD + DD + 1 + 5);
        do_reset(); go_low(); build(0, 1);
        run_stream("R8 crc abort", AD + DD + 1 + 8 * BB + 3);

        // R9 abort mid acknowledge and between blocks
        ack_en = 1'b1;
        do_reset(); go_low(); build(1, 1);
        run_stream("R9 ack abort", AD + 1);
        ack_en = 1'b0; mult = 8'd2;
        do_reset(); go_low(); build(0, 2);
        run_stream("R9 gap abort", AD + DD + 1 + 8 * BB + 16 + 1);

        // R2 exactly threshold then high: no lockout, ends idle
        mult = 8'd1;
        do_reset(); go_low();
        cmd = 1'b1;
        watch_silent("R2 threshold silent", 4);
        check("R2 threshold idle", idle && !locked, {idle, locked}, 2);

        // R3 one short of threshold: locked, silent, rearm ignored
        do_reset();
        cmd = 1'b0;
        repeat (T - 1) @(negedge clk);
        cmd = 1'b1;
        repeat (2) @(negedge clk);
        check("R3 short low locked", locked && idle, {locked, idle}, 3);
        cmd = 1'b0;
        watch_silent("R3 locked silent", T + AD + DD + 10);
        rearm = 1'b1;
        @(negedge clk);
        rearm = 1'b0;
        cmd = 1'b1;
        @(negedge clk);
        check("R3 R10 rearm ignored when locked", locked, locked, 1);
        do_reset();
        @(negedge clk);
        check("R3 reset clears lock", !locked, locked, 0);

        // R3 command strobe before boot
        cmd = 1'b0;
        repeat (4) @(negedge clk);
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        @(negedge clk);
        check("R3 strobe locked", locked, locked, 1);
        watch_silent("R3 strobe silent", T + 10);

        // R4 boot disabled
        boot_en = 1'b0;
        do_reset();
        repeat (2) @(negedge clk);
        check("R4 disabled idle", idle && !locked, {idle, locked}, 2);
        cmd = 1'b0;
        watch_silent("R4 disabled silent", T + AD + DD + 10);
        boot_en = 1'b1;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule